// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A request carries the virtual address and the top bits of the first-level table base. The walker fetches one first-level descriptor. If that descriptor points to a second-level table, it fetches one second-level descriptor as well. It then reports the physical address, the mapping size, the domain number and the access-permission bits, or it reports a translation fault together with the level at which the fault occurred.

Memory is reached through a simple read port. The walker holds a request until the memory side accepts it. The word read comes back later on a one-cycle response strobe. Five mapping granularities are supported: 16 MB, 1 MB, 64 KB, 4 KB and 1 KB. Second-level tables come in two flavours. A coarse table holds 256 entries and a fine table holds 1024 entries. Translation caching, memory attributes and permission enforcement are handled elsewhere.

Top module: `xlat_walker`

## Requirements
- R1: A request is taken only when `req_ready` is high, and `req_ready` is high only while no walk is in progress. A `req_valid` raised during a walk has no effect on that walk's result or on its memory reads.
- R2: The first-level read address is the 18-bit table base followed by virtual address bits [31:20] and two zero bits.
- R3: Bits [1:0] of a first-level descriptor select its kind: 00 fault, 01 coarse table, 10 section, 11 fine table. A fault ends the walk after exactly one read, with `fault`=1, `fault_level`=1 and `map_size`=0.
- R4: A section with bit 18 clear gives a physical address of descriptor bits [31:20] joined to virtual address bits [19:0], with `map_size`=2, the domain taken from bits [8:5] and `ap` taken from bits [11:10]. No second read is made.
- R5: A section with bit 18 set is a 16 MB mapping. Its physical address is descriptor bits [31:24] joined to virtual address bits [23:0], and `map_size`=1.
- R6: For a coarse table, the second-level read address is first-level bits [31:10], then virtual address bits [19:12], then two zero bits.
- R7: For a fine table, the second-level read address is first-level bits [31:12], then virtual address bits [19:10], then two zero bits.
- R8: Bits [1:0] of a second-level descriptor select the page kind. 01 is 64 KB: base bits [31:16], `map_size`=3. 10 is 4 KB: base bits [31:12], `map_size`=4. 11 is 1 KB: base bits [31:10], `map_size`=5. For a page, `ap` comes from second-level bits [5:4] and the domain comes from first-level bits [8:5].
- R9: A second-level descriptor with bits [1:0]=00 ends the walk with `fault`=1, `fault_level`=2 and `map_size`=0, after exactly two reads.
- R10: `mem_req_valid` stays high, with a stable address, until `mem_req_ready` accepts the read.
- R11: `done` is high for exactly one cycle per walk. Results are valid in that cycle and are held until the next walk completes.
- R12: After reset, `req_ready`=1, `done`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 18 | First-level table base, address bits [31:14] |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor word address (byte address) |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Descriptor word read |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| fault_level | output | 2 | 1 or 2 on a fault, 0 otherwise |
| pa | output | 32 | Physical address (0 on a fault) |
| map_size | output | 3 | 0 none, 1 16 MB, 2 1 MB, 3 64 KB, 4 4 KB, 5 1 KB |
| domain | output | 4 | Domain number from the first-level descriptor |
| ap | output | 2 | Access-permission bits |

## Verification
The bench sets the supersection bit, because a walker that missed it would return a 1 MB address that keeps descriptor bits [23:20] in place of virtual address bits. It runs coarse and fine tables against each other, because a shared index width would send the fine-table read to the wrong word. It checks faults at both levels and counts the reads, so any read issued after a fault shows up. It also stalls memory acceptance and raises a second request in the middle of a walk, which exposes a request address that moves while stalled, and a walker that lets a busy-time request corrupt the walk in flight.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int AW        = 32;
  localparam int BASE_LSB  = 14;
  localparam int SUPER_BIT = 18;

  typedef enum logic [2:0] {
    SZ_NONE = 3'd0, SZ_16M = 3'd1, SZ_1M = 3'd2,
    SZ_64K  = 3'd3, SZ_4K  = 3'd4, SZ_1K = 3'd5
  } map_size_e;

  typedef enum logic [1:0] {
    D1_FAULT = 2'b00, D1_COARSE = 2'b01, D1_SECTION = 2'b10, D1_FINE = 2'b11
  } d1_kind_e;

  typedef enum logic [1:0] {
    D2_FAULT = 2'b00, D2_LARGE = 2'b01, D2_SMALL = 2'b10, D2_TINY = 2'b11
  } d2_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_RSP, ST_L2_REQ, ST_L2_RSP
  } walk_state_e;

  // word address of the first-level entry
  function automatic logic [AW-1:0] l1_fetch_addr(logic [AW-1:BASE_LSB] base,
                                                  logic [AW-1:0] va);
    return {base, va[31:20], 2'b00};
  endfunction

  // word address of the second-level entry; table flavour from the L1 type
  function automatic logic [AW-1:0] l2_fetch_addr(logic [AW-1:0] d1,
                                                  logic [AW-1:0] va);
    if (d1_kind_e'(d1[1:0]) == D1_FINE)
      return {d1[31:12], va[19:10], 2'b00};
    return {d1[31:10], va[19:12], 2'b00};
  endfunction

  // physical address from descriptor frame bits and page offset
  function automatic logic [AW-1:0] compose_pa(logic [AW-1:0] desc,
                                               logic [AW-1:0] va,
                                               map_size_e sz);
    case (sz)
      SZ_16M:  return {desc[31:24], va[23:0]};
      SZ_1M:   return {desc[31:20], va[19:0]};
      SZ_64K:  return {desc[31:16], va[15:0]};
      SZ_4K:   return {desc[31:12], va[11:0]};
      SZ_1K:   return {desc[31:10], va[9:0]};
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
  import xlat_pkg::*;
(
  input  logic [AW-1:0] desc,
  output logic          is_fault,
  output logic          is_table,
  output map_size_e     size,
  output logic [3:0]    dom,
  output logic [1:0]    perm
);
  d1_kind_e kind;

  always_comb begin
    kind     = d1_kind_e'(desc[1:0]);
    is_fault = (kind == D1_FAULT);
    is_table = (kind == D1_COARSE) || (kind == D1_FINE);
    if (kind == D1_SECTION)
      size = desc[SUPER_BIT] ? SZ_16M : SZ_1M;
    else
      size = SZ_NONE;
    dom  = desc[8:5];
    perm = desc[11:10];
  end
endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
  import xlat_pkg::*;
(
  input  logic [AW-1:0] desc,
  output logic          is_fault,
  output map_size_e     size,
  output logic [1:0]    perm
);
  d2_kind_e kind;

  always_comb begin
    kind     = d2_kind_e'(desc[1:0]);
    is_fault = (kind == D2_FAULT);
    case (kind)
      D2_LARGE: size = SZ_64K;
      D2_SMALL: size = SZ_4K;
      D2_TINY:  size = SZ_1K;
      default:  size = SZ_NONE;
    endcase
    perm = desc[5:4];
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   req_vaddr,
  input  logic [17:0]   tbl_base,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          done,
  output logic          fault,
  output logic [1:0]    fault_level,
  output logic [31:0]   pa,
  output logic [2:0]    map_size,
  output logic [3:0]    domain,
  output logic [1:0]    ap
);

  walk_state_e         state_q, state_d;
  logic [AW-1:0]       va_q;
  logic [AW-1:BASE_LSB] base_q;
  logic [AW-1:0]       d1_q;

  logic                done_q, fault_q;
  logic [1:0]          lvl_q;
  logic [AW-1:0]       pa_q;
  map_size_e           size_q;
  logic [3:0]          dom_q;
  logic [1:0]          ap_q;

  // named events
  logic walk_start, mem_accept, l1_take, l2_take, l1_final, walk_end;

  // decoders look at the live response word
  logic      l1_fault, l1_table;
  map_size_e l1_size;
  logic [3:0] l1_dom;
  logic [1:0] l1_ap;
  logic      l2_fault;
  map_size_e l2_size;
  logic [1:0] l2_ap;

  xlat_l1_decode u_l1 (
    .desc(mem_rsp_data), .is_fault(l1_fault), .is_table(l1_table),
    .size(l1_size), .dom(l1_dom), .perm(l1_ap)
  );

  xlat_l2_decode u_l2 (
    .desc(mem_rsp_data), .is_fault(l2_fault), .size(l2_size), .perm(l2_ap)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_req_addr  = (state_q == ST_L2_REQ) ? l2_fetch_addr(d1_q, va_q)
                                                : l1_fetch_addr(base_q, va_q);

  assign walk_start = req_valid && req_ready;
  assign mem_accept = mem_req_valid && mem_req_ready;
  assign l1_take    = (state_q == ST_L1_RSP) && mem_rsp_valid;
  assign l2_take    = (state_q == ST_L2_RSP) && mem_rsp_valid;
  assign l1_final   = l1_take && !l1_table;
  assign walk_end   = l1_final || l2_take;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (walk_start) state_d = ST_L1_REQ;
      ST_L1_REQ: if (mem_accept) state_d = ST_L1_RSP;
      ST_L1_RSP: if (l1_take)    state_d = l1_table ? ST_L2_REQ : ST_IDLE;
      ST_L2_REQ: if (mem_accept) state_d = ST_L2_RSP;
      ST_L2_RSP: if (l2_take)    state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      d1_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      lvl_q   <= 2'd0;
      pa_q    <= '0;
      size_q  <= SZ_NONE;
      dom_q   <= '0;
      ap_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= walk_end;
      if (walk_start) begin
        va_q   <= req_vaddr;
        base_q <= tbl_base;
      end
      if (l1_take && l1_table)
        d1_q <= mem_rsp_data;
      if (l1_final) begin
        fault_q <= l1_fault;
        lvl_q   <= l1_fault ? 2'd1 : 2'd0;
        size_q  <= l1_size;
        pa_q    <= compose_pa(mem_rsp_data, va_q, l1_size);
        dom_q   <= l1_fault ? 4'd0 : l1_dom;
        ap_q    <= l1_fault ? 2'd0 : l1_ap;
      end
      if (l2_take) begin
        fault_q <= l2_fault;
        lvl_q   <= l2_fault ? 2'd2 : 2'd0;
        size_q  <= l2_size;
        pa_q    <= compose_pa(mem_rsp_data, va_q, l2_size);
        dom_q   <= d1_q[8:5];
        ap_q    <= l2_fault ? 2'd0 : l2_ap;
      end
    end
  end

  assign done        = done_q;
  assign fault       = fault_q;
  assign fault_level = lvl_q;
  assign pa          = pa_q;
  assign map_size    = size_q;
  assign domain      = dom_q;
  assign ap          = ap_q;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_level,
  input logic [2:0]  map_size,
  input logic        walk_start,
  input logic        mem_accept
);
  logic [1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          rd_cnt <= 2'd0;
    else if (walk_start)                 rd_cnt <= 2'd0;
    else if (mem_accept && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
  end

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_idle_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  p_l1_fault_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && fault_level == 2'd1 |-> rd_cnt == 2'd1);

  p_fault_no_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> map_size == 3'd0);

  p_section_one_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (map_size == 3'd1 || map_size == 3'd2) |-> rd_cnt == 2'd1);

  p_page_two_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && (map_size >= 3'd3) |-> rd_cnt == 2'd2);

  p_l2_fault_two_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && fault_level == 2'd2 |-> rd_cnt == 2'd2);

  p_hold_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .fault(fault),
  .fault_level(fault_level), .map_size(map_size),
  .walk_start(walk_start), .mem_accept(mem_accept)
);

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [17:0] tbl_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [1:0]  fault_level;
  logic [31:0] pa;
  logic [2:0]  map_size;
  logic [3:0]  domain;
  logic [1:0]  ap;

  always #4 clk = ~clk;  // 125 MHz

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_level(fault_level), .pa(pa), .map_size(map_size),
    .domain(domain), .ap(ap)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // memory model state
  logic [31:0] m_d1, m_d2, m_l1addr;
  int          m_lat = 1;
  bit          m_stall = 1'b0;
  int          stall_ctr = 0;
  int          rsp_cnt = 0;
  logic [31:0] rsp_word;
  int          rd_n;
  logic [31:0] rd_addr [0:3];

  // captured results
  logic        r_done_seen;
  logic [31:0] r_pa;
  logic [2:0]  r_size;
  logic [3:0]  r_dom;
  logic [1:0]  r_ap;
  logic        r_fault;
  logic [1:0]  r_lvl;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0BAD_F00D;
    if (rsp_cnt > 0) begin
      rsp_cnt = rsp_cnt - 1;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rsp_word;
      end
    end
    stall_ctr = stall_ctr + 1;
    mem_req_ready = !m_stall || (stall_ctr % 3 == 0);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (rd_n < 4) rd_addr[rd_n] = mem_req_addr;
      rd_n = rd_n + 1;
      rsp_word = (mem_req_addr == m_l1addr) ? m_d1 : m_d2;
      rsp_cnt  = m_lat;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_l1(logic [31:0] va, logic [17:0] b);
    return (32'(b) << 14) | ((va >> 20) << 2);
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // start a walk, wait for done, capture results
  task automatic walk(input logic [31:0] va, input logic [17:0] b,
                      input logic [31:0] d1, input logic [31:0] d2,
                      input int lat, input bit stall, input bit poke_busy);
    m_d1 = d1; m_d2 = d2; m_lat = lat; m_stall = stall;
    m_l1addr = exp_l1(va, b);
    rd_n = 0;
    for (int i = 0; i < 4; i++) rd_addr[i] = 32'hFFFF_FFFF;
    r_done_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; tbl_base = b;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      req_valid = 1'b1; req_vaddr = ~va; tbl_base = ~b;
      chk("R1", "ready while busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    for (int n = 0; n < 200 && !r_done_seen; n++) begin
      if (done) begin
        r_done_seen = 1'b1;
        r_pa = pa; r_size = map_size; r_dom = domain; r_ap = ap;
        r_fault = fault; r_lvl = fault_level;
      end else begin
        @(negedge clk);
      end
    end
    chk("R11", "done seen", {31'd0, r_done_seen}, 32'd1);
    @(negedge clk);
    chk("R11", "done width", {31'd0, done}, 32'd0);
    chk("R11", "pa held", pa, r_pa);
    chk("R2", "l1 read addr", rd_addr[0], m_l1addr);
  endtask

  task automatic t_reset();
    chk("R12", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R12", "done", {31'd0, done}, 32'd0);
    chk("R12", "mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_section(input logic [31:0] va, input logic [17:0] b,
                           input bit stall, input bit poke);
    logic [31:0] d1 = 32'hABC0_0000 | (32'd3 << 10) | (32'd9 << 5) | 32'd2;
    walk(va, b, d1, 32'h0, 2, stall, poke);
    chk("R4", "section pa", r_pa, (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF));
    chk("R4", "section size", 32'(r_size), 32'd2);
    chk("R4", "section domain", 32'(r_dom), 32'd9);
    chk("R4", "section ap", 32'(r_ap), 32'd3);
    chk("R4", "section reads", rd_n, 1);
    if (poke) chk("R1", "busy request reads", rd_n, 1);
  endtask

  task automatic t_super(input logic [31:0] va, input logic [17:0] b);
    logic [31:0] d1 = 32'h5A00_0000 | (32'd1 << 18) | (32'd1 << 10) | (32'd4 << 5) | 32'd2;
    walk(va, b, d1, 32'h0, 1, 1'b0, 1'b0);
    chk("R5", "super pa", r_pa, (d1 & 32'hFF00_0000) | (va & 32'h00FF_FFFF));
    chk("R5", "super size", 32'(r_size), 32'd1);
    chk("R5", "super reads", rd_n, 1);
  endtask

  task automatic t_l1_fault(input logic [31:0] va, input logic [17:0] b);
    walk(va, b, 32'hFFFF_FFFC, 32'h0000_1002, 1, 1'b1, 1'b0);
    chk("R3", "l1 fault flag", {31'd0, r_fault}, 32'd1);
    chk("R3", "l1 fault level", 32'(r_lvl), 32'd1);
    chk("R3", "l1 fault size", 32'(r_size), 32'd0);
    repeat (3) @(negedge clk);
    chk("R3", "l1 fault reads", rd_n, 1);
  endtask

  // fine = 1 selects a fine table; d2 holds the page descriptor
  task automatic t_page(input logic [31:0] va, input logic [17:0] b,
                        input bit fine, input logic [31:0] d2,
                        input int lat, input bit stall);
    logic [31:0] d1, e_l2, e_pa;
    logic [31:0] e_size;
    if (fine) begin
      d1   = 32'h0045_6000 | (32'd3 << 5) | 32'd3;
      e_l2 = (d1 & 32'hFFFF_F000) | (((va >> 10) & 32'h3FF) << 2);
    end else begin
      d1   = 32'h0012_3400 | (32'd15 << 5) | 32'd1;
      e_l2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
    end
    case (d2[1:0])
      2'b01: begin e_size = 3; e_pa = (d2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF); end
      2'b10: begin e_size = 4; e_pa = (d2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF); end
      2'b11: begin e_size = 5; e_pa = (d2 & 32'hFFFF_FC00) | (va & 32'h0000_03FF); end
      default: begin e_size = 0; e_pa = 0; end
    endcase
    walk(va, b, d1, d2, lat, stall, 1'b0);
    if (fine) chk("R7", "fine l2 addr", rd_addr[1], e_l2);
    else      chk("R6", "coarse l2 addr", rd_addr[1], e_l2);
    chk("R8", "page reads", rd_n, 2);
    if (d2[1:0] == 2'b00) begin
      chk("R9", "l2 fault flag", {31'd0, r_fault}, 32'd1);
      chk("R9", "l2 fault level", 32'(r_lvl), 32'd2);
      chk("R9", "l2 fault size", 32'(r_size), 32'd0);
    end else begin
      chk("R8", "page pa", r_pa, e_pa);
      chk("R8", "page size", 32'(r_size), e_size);
      chk("R8", "page ap", 32'(r_ap), 32'((d2 >> 4) & 32'h3));
      chk("R8", "page domain", 32'(r_dom), 32'((d1 >> 5) & 32'hF));
      chk("R8", "page no fault", {31'd0, r_fault}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rd_n = 0;
    m_d1 = '0; m_d2 = '0; m_l1addr = '0; rsp_word = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_section(32'h1234_5678, 18'h20001, 1'b0, 1'b0);
    t_section(32'hFEDC_BA98, 18'h00007, 1'b1, 1'b1);
    t_super(32'h1234_5678, 18'h20001);
    t_l1_fault(32'h0ABC_DEF0, 18'h3FFFF);
    t_page(32'h1234_5678, 18'h20001, 1'b0, 32'h7654_3000 | 32'h20 | 32'h2, 1, 1'b0);
    t_page(32'h1234_5678, 18'h20001, 1'b0, 32'h9876_0000 | 32'h30 | 32'h1, 2, 1'b1);
    t_page(32'hFEDC_BA98, 18'h00007, 1'b1, 32'hCAFE_F400 | 32'h10 | 32'h3, 3, 1'b0);
    t_page(32'hFEDC_BA98, 18'h00007, 1'b1, 32'h1357_9000 | 32'h20 | 32'h2, 1, 1'b1);
    t_page(32'h1234_5678, 18'h20001, 1'b0, 32'hFFFF_FFFC, 1, 1'b1);
    t_page(32'h0000_0000, 18'h00000, 1'b1, 32'hFFFF_FFFC, 2, 1'b0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule